// File: doc/BRIEF.md
# Latched 3-to-8 Decoder / Demultiplexer

This block turns a 3-bit select address into one active line out of eight. A level-sensitive address latch sits ahead of the decode. While the hold input is low, the latch is open and the outputs track the select bus. While it is high, the address that was present when hold rose is kept, and the outputs no longer respond to the select bus. The latch has no clock.

Two output-enable inputs, one active-low and one active-high, act on the outputs after the decode. Wider address decoders can be built by tying upper address bits of a larger bus to these enables on several copies of the block. The enables are not latched. They override the outputs at once, whatever the hold input is doing.

A build-time parameter sets the output polarity. With the active-low setting, the chosen line is 0 and the idle lines are 1. With the active-high setting, the chosen line is 1 and the idle lines are 0. The latch has two named modes: OPEN, entered whenever hold is low, and HOLD, entered whenever hold is high. There are no other states or transitions.

Top module: `latched_decoder`

## Requirements
- R1: With hold low and the outputs enabled, output line i is at the active level exactly when the select value equals i, and the select value is read as binary with bit 0 as the least significant bit.
- R2: While hold is high, changes on the select bus have no effect on the outputs. The decoded line stays the one whose address was on the select bus when hold rose.
- R3: When hold returns low, the outputs follow the present select value again.
- R4: The outputs are enabled only when `en_n_i` is 0 and `en_i` is 1. In the other three enable combinations, all eight lines sit at the idle level, whatever the address.
- R5: The enables are not latched. Disabling while hold is high forces all lines idle at once. Re-enabling while hold is still high shows the held address again, not the current select value.
- R6: Parameter `ACTIVE_LOW` = 1 makes the active level 0 and the idle level 1. `ACTIVE_LOW` = 0 makes the active level 1 and the idle level 0.
- R7: Whenever the outputs are enabled, exactly one of the eight lines is at the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | SEL_W (3) | Binary select address, bit 0 least significant |
| hold_i | input | 1 | High keeps the current address in the latch; low makes the latch transparent |
| en_n_i | input | 1 | Active-low output enable |
| en_i | input | 1 | Active-high output enable |
| line_o | output | 2**SEL_W (8) | Decoded lines at the polarity chosen by ACTIVE_LOW |

## Verification
The bench goes after these corner cases:

- **Bit order.** It walks all eight addresses with the latch open, in both polarities. A design that reversed the bit order or inverted the wrong level would light the wrong line.
- **Hold after a change.** It closes the latch and then sweeps the select bus through every value. A design that ignored hold, or caught the address one step late, would let a line move.
- **Disable and re-enable under hold.** It disables and re-enables while hold stays high. A design that latched the enables, or re-read the address on enable, would show a stale gate or the wrong line.
- **Disabled combinations.** It drives all three disabled enable combinations. A design that checked only one enable would leave a line active when it should be idle.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // Latch modes: OPEN follows the select bus, HOLD keeps the captured address.
    typedef enum logic {
        LATCH_OPEN = 1'b0,
        LATCH_HOLD = 1'b1
    } latch_mode_e;

endpackage

// File: rtl/addr_latch.sv
module addr_latch
    import dec_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             hold_i,
    output logic [SEL_W-1:0] addr_o
);

    latch_mode_e mode;

    assign mode = hold_i ? LATCH_HOLD : LATCH_OPEN;

    // Level-sensitive storage: transparent in OPEN, frozen in HOLD.
    always_latch begin
        if (mode == LATCH_OPEN) begin
            addr_o <= sel_i;
        end
    end

endmodule

// File: rtl/onehot_decode.sv
module onehot_decode #(
    parameter int SEL_W = 3,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr_i,
    output logic [OUT_N-1:0] line_o
);

    always_comb begin
        line_o = '0;
        line_o[addr_i] = 1'b1;

        // R7: the decode never produces zero or several lines.
        assert_single_line_R7: assert ($countones(line_o) == 1)
            else $error("decode produced %b", line_o);

        // R1: the set bit sits at the binary index given by the address.
        for (int i = 0; i < OUT_N; i++) begin
            if (addr_i == SEL_W'(i)) begin
                assert_index_match_R1: assert (line_o[i] == 1'b1)
                    else $error("line %0d not set for address %0d", i, addr_i);
            end
        end
    end

endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int   OUT_N      = 8,
    parameter logic ACTIVE_LOW = 1'b1
) (
    input  logic [OUT_N-1:0] line_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [OUT_N-1:0] line_o
);

    localparam logic IDLE_LVL = ACTIVE_LOW;

    logic             pass;
    logic [OUT_N-1:0] gated;

    always_comb begin
        pass   = ~en_n_i & en_i;
        gated  = pass ? line_i : '0;
        line_o = ACTIVE_LOW ? ~gated : gated;

        if (!pass) begin
            // R4: disabled means every line idle.
            assert_idle_when_off_R4: assert (line_o == {OUT_N{IDLE_LVL}})
                else $error("disabled but lines = %b", line_o);
        end else begin
            // R6: exactly one line differs from the idle level, and it is the decoded one.
            assert_polarity_R6: assert ($countones(line_o ^ {OUT_N{IDLE_LVL}}) == 1
                                        && ((line_o ^ {OUT_N{IDLE_LVL}}) == line_i))
                else $error("enabled lines = %b for decode %b", line_o, line_i);
        end
    end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
    parameter int   SEL_W      = 3,
    parameter logic ACTIVE_LOW = 1'b1,
    localparam int  OUT_N      = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             hold_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [OUT_N-1:0] line_o
);

    logic [SEL_W-1:0] held_addr;
    logic [OUT_N-1:0] raw_line;

    addr_latch #(
        .SEL_W (SEL_W)
    ) latch_i (
        .sel_i  (sel_i),
        .hold_i (hold_i),
        .addr_o (held_addr)
    );

    onehot_decode #(
        .SEL_W (SEL_W)
    ) decode_i (
        .addr_i (held_addr),
        .line_o (raw_line)
    );

    out_gate #(
        .OUT_N      (OUT_N),
        .ACTIVE_LOW (ACTIVE_LOW)
    ) gate_i (
        .line_i (raw_line),
        .en_n_i (en_n_i),
        .en_i   (en_i),
        .line_o (line_o)
    );

endmodule

// File: tb/latched_decoder_tb_top.sv
module latched_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] lo;
        logic [7:0] hi;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = '0;
    logic       hold = 1'b0;
    logic       en_n = 1'b1;
    logic       en = 1'b0;
    logic [7:0] out_lo;
    logic [7:0] out_hi;

    exp_t       sb_q[$];
    logic [2:0] m_held = '0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b1)) dut_i (
        .sel_i (sel), .hold_i (hold), .en_n_i (en_n), .en_i (en), .line_o (out_lo)
    );

    latched_decoder #(.SEL_W(3), .ACTIVE_LOW(1'b0)) dut_hi_i (
        .sel_i (sel), .hold_i (hold), .en_n_i (en_n), .en_i (en), .line_o (out_hi)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Driver: apply one input set and queue what the requirements predict.
    task automatic drive(input logic [2:0] a, input logic h, input logic e_n,
                         input logic e, input string tag);
        exp_t       item;
        logic [7:0] act;
        @(posedge clk);
        sel  = a;
        hold = h;
        en_n = e_n;
        en   = e;
        if (!h) m_held = a;
        act = (!e_n && e) ? (8'b1 << m_held) : 8'b0;
        item.hi  = act;
        item.lo  = ~act;
        item.tag = tag;
        sb_q.push_back(item);
    endtask

    // Monitor: compare away from the driving edge.
    initial begin
        exp_t item;
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                item = sb_q.pop_front();
                n_checks++;
                if (out_lo !== item.lo) begin
                    n_fail++;
                    $display("FAIL %s (R6 active-low) got %b expected %b", item.tag, out_lo, item.lo);
                end
                n_checks++;
                if (out_hi !== item.hi) begin
                    n_fail++;
                    $display("FAIL %s (R6 active-high) got %b expected %b", item.tag, out_hi, item.hi);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, got no end expected end");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-like idle state: outputs disabled (R4).
        drive(3'd0, 1'b0, 1'b1, 1'b0, "R4 idle start");
        // R1 and R7: every address with the latch open.
        for (int a = 0; a < 8; a++) drive(3'(a), 1'b0, 1'b0, 1'b1, "R1 R7 open decode");
        // R2: capture 5, then sweep the select bus.
        drive(3'd5, 1'b0, 1'b0, 1'b1, "R1 before hold");
        drive(3'd5, 1'b1, 1'b0, 1'b1, "R2 hold rises");
        for (int a = 0; a < 8; a++) drive(3'(a), 1'b1, 1'b0, 1'b1, "R2 select ignored");
        // R3: reopen and follow.
        drive(3'd2, 1'b0, 1'b0, 1'b1, "R3 reopen");
        drive(3'd7, 1'b0, 1'b0, 1'b1, "R3 follow");
        // R4: each disabled combination over all addresses.
        for (int c = 0; c < 4; c++) begin
            if (c != 1) begin
                for (int a = 0; a < 8; a++)
                    drive(3'(a), 1'b0, c[1], c[0], "R4 disabled combo");
            end
        end
        drive(3'd4, 1'b0, 1'b0, 1'b1, "R4 enabled combo");
        // R5: enables act immediately during hold.
        drive(3'd6, 1'b0, 1'b0, 1'b1, "R5 setup");
        drive(3'd6, 1'b1, 1'b0, 1'b1, "R5 held");
        drive(3'd1, 1'b1, 1'b1, 1'b1, "R5 disable in hold");
        drive(3'd3, 1'b1, 1'b0, 1'b0, "R5 disable in hold");
        drive(3'd4, 1'b1, 1'b0, 1'b1, "R5 re-enable shows held");
        drive(3'd4, 1'b0, 1'b0, 1'b1, "R3 release after R5");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule